// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

A purely combinational integer arithmetic and logic unit for the execute stage of a small load/store processor. A decoded 6-bit operation selector picks one of ten operations: trapping and non-trapping add and subtract, signed and unsigned set-less-than, and the bitwise AND, OR, NOR and XOR. Selector 0 passes the second operand through unchanged, which is the zero-distance shift case. The result is available in the same cycle the inputs are presented. Besides the result, the block drives a destination write-enable, an overflow-trap flag for the exception logic, and an illegal-operation flag.

The second operand is either the register value or a 16-bit constant taken from the instruction. A 2-bit mode input chooses the source. In the immediate modes it also sets how the constant is widened: sign-extended, zero-extended, or placed in the upper half with zeros below. The decoder that drives this block sets the mode to sign-extend for arithmetic and compares, to zero-extend for logical operations, and to upper placement (with selector 0) for load-upper-immediate. The block only raises the overflow flag. Redirecting the program counter and recording the cause belong elsewhere.

Top module: `int_alu`

## Requirements
- R1: Selector 32 (trapping add) and selector 33 (non-trapping add) produce the sum of the two operands modulo 2^32.
- R2: Selector 34 (trapping subtract) and selector 35 (non-trapping subtract) produce first operand minus second operand modulo 2^32.
- R3: `ovfTrap` is 1 only for selector 32 or 34 when the signed result overflows. For add, overflow means both operands share a sign and the result sign differs. For subtract, it means the operand signs differ and the result sign differs from the first operand. Selectors 33 and 35 never raise it.
- R4: `writeEn` is 1 for every recognised selector unless `ovfTrap` is 1. When the trap is raised, `result` still carries the wrapped arithmetic value.
- R5: Selector 42 returns 1 when the first operand is less than the second in two's complement, and 0 otherwise. All upper 31 bits are zero.
- R6: Selector 43 returns 1 when the first operand is less than the second as unsigned integers, and 0 otherwise.
- R7: Selectors 36, 37, 39 and 40 return the bitwise AND, OR, NOR and XOR of the operands.
- R8: With `immMode` = 1, the second operand is `immVal` with bit 15 copied into bits 31..16. `opB` is ignored.
- R9: With `immMode` = 2, the second operand is `immVal` with bits 31..16 zero. With `immMode` = 0, it is `opB`.
- R10: With `immMode` = 3, the second operand is `immVal` in bits 31..16 with bits 15..0 zero. Selector 0 returns the second operand unchanged.
- R11: Any other selector value yields `result` = 0, `illegalOp` = 1, `writeEn` = 0 and `ovfTrap` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 6 | Decoded operation selector (function-code value) |
| immMode | input | 2 | Second-operand source: 0 register, 1 sign-extended, 2 zero-extended, 3 upper-half constant |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand from the register file |
| immVal | input | 16 | Constant from the instruction |
| result | output | 32 | Operation result |
| ovfTrap | output | 1 | Signed overflow on a trapping add or subtract |
| writeEn | output | 1 | Destination register may be written |
| illegalOp | output | 1 | Selector is not a recognised operation |

## Verification
The hardest cases to reach are the overflow boundaries. Subtracting the most negative value from zero, or adding two large positives, must raise the trap on the trapping forms and stay silent on the wrapping forms, and the signed compare must still give the right answer when the internal difference has overflowed. The stimulus sweeps all 64 selector values against a set of operands built around the sign boundary: 0, 1, all ones, the largest positive and most negative values, and their neighbours. It does this for register operands and for every immediate mode, with constants whose bit 15 is set and clear. Every such pairing is therefore reached with every selector, including the unrecognised ones.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int SEL_W = 6;

  typedef enum logic [5:0] {
    SEL_PASS = 6'd0,
    SEL_ADD  = 6'd32,
    SEL_ADDU = 6'd33,
    SEL_SUB  = 6'd34,
    SEL_SUBU = 6'd35,
    SEL_AND  = 6'd36,
    SEL_OR   = 6'd37,
    SEL_NOR  = 6'd39,
    SEL_XOR  = 6'd40,
    SEL_SLT  = 6'd42,
    SEL_SLTU = 6'd43
  } alu_sel_e;

  typedef enum logic [1:0] {
    IMM_NONE  = 2'd0,
    IMM_SEXT  = 2'd1,
    IMM_ZEXT  = 2'd2,
    IMM_UPPER = 2'd3
  } imm_mode_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } logic_op_e;

  typedef enum logic [2:0] {
    RS_ZERO  = 3'd0,
    RS_SUM   = 3'd1,
    RS_LOGIC = 3'd2,
    RS_LESS  = 3'd3,
    RS_PASS  = 3'd4
  } res_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      doSub;
    logic      trapEn;
    logic      lessSigned;
    logic_op_e logicOp;
    res_sel_e  resSel;
    logic      legal;
  } alu_strobe_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [SEL_W-1:0] opSel,
  output alu_strobe_t      strobes
);

  always_comb begin
    strobes.doSub      = 1'b0;
    strobes.trapEn     = 1'b0;
    strobes.lessSigned = 1'b0;
    strobes.logicOp    = LG_AND;
    strobes.resSel     = RS_ZERO;
    strobes.legal      = 1'b1;
    case (opSel)
      SEL_PASS: strobes.resSel = RS_PASS;
      SEL_ADD: begin
        strobes.resSel = RS_SUM;
        strobes.trapEn = 1'b1;
      end
      SEL_ADDU: strobes.resSel = RS_SUM;
      SEL_SUB: begin
        strobes.resSel = RS_SUM;
        strobes.doSub  = 1'b1;
        strobes.trapEn = 1'b1;
      end
      SEL_SUBU: begin
        strobes.resSel = RS_SUM;
        strobes.doSub  = 1'b1;
      end
      SEL_AND: strobes.resSel = RS_LOGIC;
      SEL_OR: begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_OR;
      end
      SEL_NOR: begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_NOR;
      end
      SEL_XOR: begin
        strobes.resSel  = RS_LOGIC;
        strobes.logicOp = LG_XOR;
      end
      SEL_SLT: begin
        strobes.resSel     = RS_LESS;
        strobes.doSub      = 1'b1;
        strobes.lessSigned = 1'b1;
      end
      SEL_SLTU: begin
        strobes.resSel = RS_LESS;
        strobes.doSub  = 1'b1;
      end
      default: strobes.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/int_alu_operand.sv
module int_alu_operand
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [1:0]        immMode,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] opBEff
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immSext;
  logic [DATA_W-1:0] immZext;
  logic [DATA_W-1:0] immUpper;

  generate
    if (PAD_W > 0) begin : g_pad
      assign immSext  = {{PAD_W{immVal[IMM_W-1]}}, immVal};
      assign immZext  = {{PAD_W{1'b0}}, immVal};
      assign immUpper = {immVal, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign immSext  = immVal[DATA_W-1:0];
      assign immZext  = immVal[DATA_W-1:0];
      assign immUpper = immVal[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (immMode)
      IMM_SEXT:  opBEff = immSext;
      IMM_ZEXT:  opBEff = immZext;
      IMM_UPPER: opBEff = immUpper;
      default:   opBEff = opB;
    endcase
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_strobe_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opBEff,
  output logic [DATA_W-1:0] result,
  output logic              ovfTrap
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bInv;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              ovfRaw;
  logic              lessBit;
  logic [DATA_W-1:0] logicRes;

  // One shared adder: subtract is a + ~b + 1
  assign bInv     = strobes.doSub ? ~opBEff : opBEff;
  assign sumWide  = {1'b0, opA} + {1'b0, bInv} + {{DATA_W{1'b0}}, strobes.doSub};
  assign sum      = sumWide[MSB:0];
  assign carryOut = sumWide[DATA_W];

  // Operands of the adder agree in sign, sum sign departs from it
  assign ovfRaw = (opA[MSB] == bInv[MSB]) && (sum[MSB] != opA[MSB]);

  // Signed less: difference sign corrected by overflow; unsigned: borrow
  assign lessBit = strobes.lessSigned ? (sum[MSB] ^ ovfRaw) : ~carryOut;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_logic
      always_comb begin
        case (strobes.logicOp)
          LG_AND:  logicRes[i] = opA[i] & opBEff[i];
          LG_OR:   logicRes[i] = opA[i] | opBEff[i];
          LG_NOR:  logicRes[i] = ~(opA[i] | opBEff[i]);
          default: logicRes[i] = opA[i] ^ opBEff[i];
        endcase
      end
    end
  endgenerate

  always_comb begin
    case (strobes.resSel)
      RS_SUM:   result = sum;
      RS_LOGIC: result = logicRes;
      RS_LESS:  result = {{(DATA_W-1){1'b0}}, lessBit};
      RS_PASS:  result = opBEff;
      default:  result = '0;
    endcase
  end

  assign ovfTrap = strobes.trapEn & ovfRaw;

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [5:0]        opSel,
  input  logic [1:0]        immMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              ovfTrap,
  output logic              writeEn,
  output logic              illegalOp
);

  alu_strobe_t       strobes;
  logic [DATA_W-1:0] opBEff;

  int_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  int_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operand (
    .immMode (immMode),
    .opB     (opB),
    .immVal  (immVal),
    .opBEff  (opBEff)
  );

  int_alu_datapath #(.DATA_W(DATA_W)) u_datapath (
    .strobes (strobes),
    .opA     (opA),
    .opBEff  (opBEff),
    .result  (result),
    .ovfTrap (ovfTrap)
  );

  assign illegalOp = ~strobes.legal;
  assign writeEn   = strobes.legal & ~ovfTrap;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic [5:0]        opSel,
  input logic [1:0]        immMode,
  input logic [DATA_W-1:0] result,
  input logic              ovfTrap,
  input logic              writeEn,
  input logic              illegalOp
);

  always_comb begin
    // R3: trap only from trapping add/subtract
    a_r3_trap_source: assert (!ovfTrap || opSel == 6'd32 || opSel == 6'd34)
      else $error("ovfTrap raised for selector %0d", opSel);
    // R4: trapped result is never written
    a_r4_no_write_on_trap: assert (!ovfTrap || !writeEn)
      else $error("writeEn with ovfTrap");
    // R11: unrecognised selector is silent
    a_r11_illegal_quiet: assert (!illegalOp || (result == '0 && !writeEn && !ovfTrap))
      else $error("illegal selector produced output");
    // R5 / R6: compare result is 0 or 1
    a_r5_less_is_bit: assert (!((opSel == 6'd42 || opSel == 6'd43) && !illegalOp)
                              || result[DATA_W-1:1] == '0)
      else $error("compare result has upper bits set");
    // R10: upper-constant pass leaves low half clear
    a_r10_upper_low_zero: assert (!(immMode == 2'd3 && opSel == 6'd0) || result[15:0] == '0)
      else $error("upper constant low half not zero");
  end

endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .opSel     (opSel),
  .immMode   (immMode),
  .result    (result),
  .ovfTrap   (ovfTrap),
  .writeEn   (writeEn),
  .illegalOp (illegalOp)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  opSel = '0;
  logic [1:0]  immMode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] immVal = '0;
  logic [31:0] result;
  logic        ovfTrap, writeEn, illegalOp;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  int_alu u_dut (
    .opSel(opSel), .immMode(immMode), .opA(opA), .opB(opB), .immVal(immVal),
    .result(result), .ovfTrap(ovfTrap), .writeEn(writeEn), .illegalOp(illegalOp)
  );

  logic [31:0] corners [8] = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_8765};
  logic [15:0] imms [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s sel=%0d mode=%0d a=%h b=%h imm=%h: actual=%h expected=%h",
               req, what, opSel, immMode, opA, opB, immVal, act, exp);
    end
  endtask

  task automatic apply_and_check(input int s, input int m, input logic [31:0] a,
                                 input logic [31:0] b, input logic [15:0] imm);
    logic [31:0] bEff, expR;
    logic        expOvf, legal;
    string       rTag;
    @(negedge clk);
    opSel = s[5:0]; immMode = m[1:0]; opA = a; opB = b; immVal = imm;
    case (m)
      1: bEff = {{16{imm[15]}}, imm};
      2: bEff = {16'h0000, imm};
      3: bEff = {imm, 16'h0000};
      default: bEff = b;
    endcase
    expOvf = 1'b0; legal = 1'b1; expR = '0; rTag = "R11";
    case (s)
      0:  begin expR = bEff; rTag = "R10"; end
      32, 33: begin
        expR = a + bEff; rTag = "R1";
        expOvf = (s == 32) && (a[31] == bEff[31]) && (expR[31] != a[31]);
      end
      34, 35: begin
        expR = a - bEff; rTag = "R2";
        expOvf = (s == 34) && (a[31] != bEff[31]) && (expR[31] != a[31]);
      end
      36: begin expR = a & bEff;    rTag = "R7"; end
      37: begin expR = a | bEff;    rTag = "R7"; end
      39: begin expR = ~(a | bEff); rTag = "R7"; end
      40: begin expR = a ^ bEff;    rTag = "R7"; end
      42: begin expR = {31'b0, $signed(a) < $signed(bEff)}; rTag = "R5"; end
      43: begin expR = {31'b0, a < bEff}; rTag = "R6"; end
      default: legal = 1'b0;
    endcase
    if (legal) begin
      if (m == 1) rTag = {rTag, "/R8"};
      else if (m == 2 || m == 0) rTag = {rTag, "/R9"};
      else rTag = {rTag, "/R10"};
    end
    #1;
    check(rTag, "result", result, expR);
    check("R3", "ovfTrap", {31'b0, ovfTrap}, {31'b0, expOvf});
    check("R4", "writeEn", {31'b0, writeEn}, {31'b0, legal && !expOvf});
    check("R11", "illegalOp", {31'b0, illegalOp}, {31'b0, !legal});
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // Reset state: all-zero inputs select pass of a zero operand
    @(negedge clk); #1;
    check("R10", "reset result", result, 32'h0);
    check("R4", "reset writeEn", {31'b0, writeEn}, 32'h1);
    check("R11", "reset illegalOp", {31'b0, illegalOp}, 32'h0);
    // Directed boundary cases
    apply_and_check(34, 0, 32'h0000_0000, 32'h8000_0000, 16'h0);  // R3 0 - minint traps
    apply_and_check(35, 0, 32'h0000_0000, 32'h8000_0000, 16'h0);  // R3 wrapping form silent
    apply_and_check(32, 0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0);  // R3 / R4 add overflow
    apply_and_check(42, 0, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);  // R5 overflowed difference
    apply_and_check(43, 1, 32'h0000_0005, 32'h0, 16'hFFFF);       // R6 / R8 sext compare
    apply_and_check(36, 2, 32'hFFFF_FFFF, 32'h0, 16'h8001);       // R7 / R9 zext logic
    apply_and_check(0, 3, 32'h0, 32'hDEAD_BEEF, 16'hABCD);        // R10 upper constant
    apply_and_check(38, 0, 32'h1, 32'h1, 16'h0);                  // R11 gap selector
    // Sweep every selector against sign-boundary operands
    for (int s = 0; s < 64; s++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++)
          apply_and_check(s, 0, corners[ia], corners[ib], 16'h5A5A);
        for (int m = 1; m < 4; m++)
          for (int ii = 0; ii < 4; ii++)
            apply_and_check(s, m, corners[ia], corners[(ia + ii) % 8], imms[ii]);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule